// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers a vertical sync flag from a composite sync stream that carries short horizontal pulses and one long vertical interval per frame. It integrates the sync level with an 8-bit up/down counter that advances only on a slow tick enable. Horizontal pulses are too short to push the count past a programmable threshold. A vertical interval is long enough to do so.

Once the vertical interval is declared, the counter clears and enters a second phase. In this phase it measures how long the sync input has stayed inactive. Brief returns to active, such as serration pulses, restart that measurement. The interval ends only after the input has stayed inactive for the threshold number of ticks. The sync input is expected to be active-high already. It is resynchronised to the system clock inside the block before use.

Top module: `csync_vsep`

## Requirements
- R1: While searching, each tick raises the count by one if the synchronised sync input is 1, and lowers it by one if the input is 0. Clock cycles without a tick leave the count and the output unchanged. The input is sampled through a two-flop synchroniser.
- R2: The count saturates at 255 when counting up and holds at 0 when counting down. It never wraps.
- R3: While searching, a tick that finds the stored count above `thresh_i` sets `vsync_o` to 1 on that tick's edge and clears the count.
- R4: Pulses that keep the count at or below `thresh_i` never set `vsync_o`.
- R5: While `vsync_o` is 1, a tick with the input at 0 raises the count, and a tick with the input at 1 clears it to 0, so short active gaps do not end the interval.
- R6: While `vsync_o` is 1, a tick that finds the stored count equal to or above `thresh_i` clears `vsync_o` and the count and returns to searching. With `thresh_i` = 0 this happens on the first tick.
- R7: With `thresh_i` = 255, `vsync_o` is never set, because the count cannot exceed 255.
- R8: Asynchronous active-low reset clears the count, selects searching and drives `vsync_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle count enable (slow tick) |
| csync_i | input | 1 | Composite sync, active-high, asynchronous |
| thresh_i | input | 8 | Detection threshold in ticks |
| vsync_o | output | 1 | Registered vertical sync flag |

## Verification
The bench targets the count floor. It lowers the count from zero and then applies one short pulse. A counter that underflowed to 255 would flag vertical sync at once. It also drives a 300-tick active level with the threshold at 255, then lowers the threshold to 254. A counter that wrapped would then hold a small value and stay silent. A counter that saturated holds 255 and triggers. Serration gaps must restart the absence count: a design that only held or decremented the count would end the interval early. Idle clocks without a tick must leave the count alone. A threshold of zero must end the interval after exactly one tick.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;

  typedef enum logic {
    PH_SEARCH = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_e;
endpackage

// File: rtl/csync_sync.sv
module csync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csync_sat_cnt.sv
module csync_sat_cnt
  import csync_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      unique case (op_i)
        CNT_INC:  if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
        CNT_DEC:  if (cnt_q != '0)      cnt_d = cnt_q - CNT_ONE;
        CNT_CLR:  cnt_d = '0;
        default:  cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && op_i == CNT_INC && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R2
  sat_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && op_i == CNT_DEC && cnt_q == '0) |=> cnt_q == '0);

  // R1
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/csync_phase_fsm.sv
module csync_phase_fsm
  import csync_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output cnt_op_e          op_o,
  output logic             vsync_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    op_o    = CNT_HOLD;
    unique case (phase_q)
      PH_SEARCH: begin
        if (cnt_i > thresh_i) begin
          op_o    = CNT_CLR;
          phase_d = PH_ACTIVE;
        end else begin
          op_o = sync_i ? CNT_INC : CNT_DEC;
        end
      end
      PH_ACTIVE: begin
        if (cnt_i >= thresh_i) begin
          op_o    = CNT_CLR;
          phase_d = PH_SEARCH;
        end else begin
          op_o = sync_i ? CNT_CLR : CNT_INC;
        end
      end
      default: begin
        op_o    = CNT_CLR;
        phase_d = PH_SEARCH;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= PH_SEARCH;
    else if (tick_i) phase_q <= phase_d;
  end

  assign vsync_o = (phase_q == PH_ACTIVE);

  // R3
  enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !vsync_o && cnt_i > thresh_i) |=> (vsync_o && cnt_i == '0));

  // R6
  leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && vsync_o && cnt_i >= thresh_i) |=> (!vsync_o && cnt_i == '0));

  // R5
  gap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && vsync_o && sync_i && cnt_i < thresh_i) |=> cnt_i == '0);

  // R1
  out_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(vsync_o));
endmodule

// File: rtl/csync_vsep.sv
module csync_vsep
  import csync_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             csync_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             vsync_o
);
  logic             sync_s;
  logic [CNT_W-1:0] cnt;
  cnt_op_e          op;

  csync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (csync_i),
    .q_o    (sync_s)
  );

  csync_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .op_i   (op),
    .cnt_o  (cnt)
  );

  csync_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .sync_i   (sync_s),
    .cnt_i    (cnt),
    .thresh_i (thresh_i),
    .op_o     (op),
    .vsync_o  (vsync_o)
  );

  // R4
  no_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !vsync_o && cnt <= thresh_i) |=> !vsync_o);
endmodule

// File: tb/csync_vsep_tb.sv
module csync_vsep_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       csync_i = 1'b0;
  logic [7:0] thresh_i = 8'd20;
  logic       vsync_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  csync_vsep u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .csync_i  (csync_i),
    .thresh_i (thresh_i),
    .vsync_o  (vsync_o)
  );

  // {level, ticks[15:0], expected vsync}, threshold 20
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 16'd5,  1'b0},  // R1 short pulse up
    {1'b0, 16'd10, 1'b0},  // R4 decays
    {1'b1, 16'd21, 1'b0},  // R3 count 21 stored
    {1'b1, 16'd1,  1'b1},  // R3 declared
    {1'b0, 16'd5,  1'b1},  // R5 gap counting
    {1'b1, 16'd1,  1'b1},  // R5 serration clears
    {1'b0, 16'd20, 1'b1},  // R6 count reaches 20
    {1'b0, 16'd1,  1'b0},  // R6 released
    {1'b1, 16'd3,  1'b0}   // R1 search again
  };

  task automatic check(input string req, input logic exp);
    n_run++;
    if (vsync_o !== exp) begin
      n_fail++;
      $display("FAIL %s vsync_o actual=%b expected=%b", req, vsync_o, exp);
    end
  endtask

  task automatic set_level(input logic lvl);
    @(negedge clk_i);
    csync_i = lvl;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    csync_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    do_reset();
    check("R8", 1'b0);

    thresh_i = 8'd20;
    for (int v = 0; v < NV; v++) begin
      set_level(VEC[v][17]);
      ticks(int'(VEC[v][16:1]));
      check($sformatf("R1-vec%0d", v), VEC[v][0]);
    end

    // R8: reset in the middle of a vertical interval
    set_level(1'b1);
    ticks(22);
    check("R3", 1'b1);
    do_reset();
    check("R8", 1'b0);
    set_level(1'b1);
    ticks(21);
    check("R8", 1'b0);
    ticks(1);
    check("R3", 1'b1);

    // R2: floor at zero, no underflow
    do_reset();
    set_level(1'b0);
    ticks(5);
    set_level(1'b1);
    ticks(2);
    check("R2", 1'b0);

    // R1: idle clocks without tick do not count
    do_reset();
    set_level(1'b1);
    ticks(20);
    repeat (50) @(negedge clk_i);
    check("R1", 1'b0);
    ticks(1);
    check("R4", 1'b0);
    ticks(1);
    check("R1", 1'b1);

    // R7 and R2: saturation at 255
    do_reset();
    thresh_i = 8'd255;
    set_level(1'b1);
    ticks(300);
    check("R7", 1'b0);
    thresh_i = 8'd254;
    ticks(1);
    check("R2", 1'b1);

    // R6: threshold zero releases after one tick
    do_reset();
    thresh_i = 8'd0;
    set_level(1'b1);
    ticks(1);
    check("R6", 1'b0);
    ticks(1);
    check("R3", 1'b1);
    ticks(1);
    check("R6", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule